// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns a 64-bit address coming from the processor side into a 64-bit address for the downstream link side. It holds eight programmable windows. Each window keeps a match value, a mask and a remap value, each split into a low and a high 32-bit register, plus an action register. The action register carries the transaction kind (memory or I/O) and two attribute bits. Bit 0 of the low match register enables the window. Software writes every other field first and then rewrites the low match register with bit 0 set, so a window never goes live half programmed. A global enable bit in a separate control register gates all translation.

Every accepted request is compared against all windows in parallel. The lowest-numbered enabled window that matches supplies the remap bits wherever its mask is 1. The address bits pass through where the mask is 0. The result, together with a hit flag and the kind and attribute bits of the winning window, is held in an output register one cycle after acceptance. Both sides use a valid/ready handshake. A plain 32-bit configuration port with a write strobe and a combinational read-back lets software program and inspect the windows.

Top module: `addr_win_xlate`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Every window register and the control register read back as 0.
- R2: An enabled window hits when (in_addr AND mask) equals (match AND mask), where bit 0 of the match value takes no part in the comparison. An address that differs from the match value only in bit 0 therefore still hits.
- R3: On a hit, out_addr takes the remap bits where the window mask is 1 and the in_addr bits where the mask is 0.
- R4: When several enabled windows hit, the one with the lowest index is used.
- R5: With no hit, out_hit is 0, out_addr equals in_addr, and out_kind and out_attr are 0.
- R6: A window whose low match register has bit 0 clear never hits. Rewriting that register with bit 0 clear takes a live window out of use.
- R7: A request is accepted when in_valid and in_ready are both 1, with in_ready = !out_valid || out_ready. Its result shows up with out_valid = 1 one cycle after acceptance and stays unchanged while out_ready is 0.
- R8: The configuration map places window w at byte offset 0x20*w. Within a window, the word offsets are: match low 0x00, match high 0x04, remap low 0x08, remap high 0x0C, mask low 0x10, mask high 0x14, action 0x18. The control register is at 0x100. Writes to any other aligned address are ignored, and those addresses read 0.
- R9: The action register keeps the kind in bits 3:0 (0x0 memory, 0x4 I/O) and the attribute in bits 21:20. Its other bits read 0. On a hit, out_kind and out_attr carry these fields of the winning window.
- R10: Bit 6 of the control register is the global enable. While it is 0, no request hits, whatever the windows hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | 64 | Address to translate |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_addr | output | 64 | Translated or passed-through address |
| out_hit | output | 1 | A window matched |
| out_kind | output | 4 | Kind field of the winning window |
| out_attr | output | 2 | Attribute field of the winning window |

## Verification
Lookups are tried with the following patterns, each separating one behaviour from the others:
- A 128 MB window whose high mask is zero shows that the upper address bits pass through while the low bits are remapped.
- A full 64-bit mask shows that the high remap half is substituted.
- Two overlapping windows, hit first with both live and then with the lower one switched off, tell priority apart from plain matching.
- A window whose low match word has bit 0 set is probed with addresses that differ only in bit 0, to show that the enable bit is kept out of the comparison.
- A programmed but never enabled window shows that a miss passes the address through.
- Toggling the global enable shows that it overrides every window.

A stream of back-to-back requests under an irregular out_ready pattern checks the one-cycle latency and that stalled results hold. Writes to unmapped offsets are followed by read-back and by a repeat lookup, to show that they touch nothing.

// File: rtl/awx_pkg.sv
package awx_pkg;

   localparam int AWX_REG_W  = 32;
   localparam int AWX_ADDR_W = 2 * AWX_REG_W;
   localparam int AWX_KIND_W = 4;
   localparam int AWX_ATTR_W = 2;

   // word index inside one window register block (byte offset / 4)
   localparam int AWX_W_MATCH_LO = 0;
   localparam int AWX_W_MATCH_HI = 1;
   localparam int AWX_W_REMAP_LO = 2;
   localparam int AWX_W_REMAP_HI = 3;
   localparam int AWX_W_MASK_LO  = 4;
   localparam int AWX_W_MASK_HI  = 5;
   localparam int AWX_W_ACTION   = 6;

   typedef struct packed {
      logic [AWX_ADDR_W-1:0] addr;
      logic                  hit;
      logic [AWX_KIND_W-1:0] kind;
      logic [AWX_ATTR_W-1:0] attr;
   } awx_resp_t;

endpackage

// File: rtl/awx_regfile.sv
module awx_regfile
   import awx_pkg::*;
#(
   parameter int NUM_WIN    = 8,
   parameter int CFG_AW     = 12,
   parameter int WIN_STRIDE = 32,
   parameter int CTRL_OFS   = 256,
   parameter int GEN_EN_BIT = 6,
   parameter int KIND_LSB   = 0,
   parameter int ATTR_LSB   = 20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [AWX_REG_W-1:0]  cfg_wdata,
   output logic [AWX_REG_W-1:0]  cfg_rdata,
   output logic [AWX_ADDR_W-1:0] win_match [NUM_WIN],
   output logic [AWX_ADDR_W-1:0] win_mask  [NUM_WIN],
   output logic [AWX_ADDR_W-1:0] win_remap [NUM_WIN],
   output logic [AWX_KIND_W-1:0] win_kind  [NUM_WIN],
   output logic [AWX_ATTR_W-1:0] win_attr  [NUM_WIN],
   output logic                  glob_en
);

   localparam int OFS_W  = $clog2(WIN_STRIDE);
   localparam int IDX_W  = $clog2(NUM_WIN);
   localparam int WORD_W = OFS_W - 2;
   localparam logic [CFG_AW-1:0] WIN_SPAN  = CFG_AW'(NUM_WIN * WIN_STRIDE);
   localparam logic [CFG_AW-1:0] CTRL_ADR  = CFG_AW'(CTRL_OFS);

   // elaboration-time parameter checks
   if (NUM_WIN < 2 || (1 << IDX_W) != NUM_WIN) begin : g_bad_num
      $error("NUM_WIN must be a power of two, at least 2");
   end
   if (WIN_STRIDE < 32 || (1 << OFS_W) != WIN_STRIDE) begin : g_bad_stride
      $error("WIN_STRIDE must be a power of two, at least 32");
   end
   if (CTRL_OFS < NUM_WIN * WIN_STRIDE || CTRL_OFS >= (1 << CFG_AW) || (CTRL_OFS % 4) != 0) begin : g_bad_ctrl
      $error("CTRL_OFS must be word aligned, above the windows and inside the map");
   end
   if (GEN_EN_BIT >= AWX_REG_W) begin : g_bad_gen
      $error("GEN_EN_BIT out of range");
   end
   if (KIND_LSB + AWX_KIND_W > AWX_REG_W || ATTR_LSB + AWX_ATTR_W > AWX_REG_W) begin : g_bad_fld
      $error("action fields out of range");
   end

   logic                 aligned;
   logic                 in_win;
   logic                 at_ctrl;
   logic [IDX_W-1:0]     widx;
   logic [WORD_W-1:0]    word;

   assign aligned = (cfg_addr[1:0] == 2'b00);
   assign in_win  = aligned && (cfg_addr < WIN_SPAN);
   assign at_ctrl = (cfg_addr == CTRL_ADR);
   assign widx    = cfg_addr[OFS_W +: IDX_W];
   assign word    = cfg_addr[OFS_W-1:2];

   logic [AWX_ADDR_W-1:0] match_q [NUM_WIN];
   logic [AWX_ADDR_W-1:0] mask_q  [NUM_WIN];
   logic [AWX_ADDR_W-1:0] remap_q [NUM_WIN];
   logic [AWX_KIND_W-1:0] kind_q  [NUM_WIN];
   logic [AWX_ATTR_W-1:0] attr_q  [NUM_WIN];
   logic                  gen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            match_q[w] <= '0;
            mask_q[w]  <= '0;
            remap_q[w] <= '0;
            kind_q[w]  <= '0;
            attr_q[w]  <= '0;
         end
      end else if (cfg_we && in_win) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            if (widx == IDX_W'(w)) begin
               case (word)
                  WORD_W'(AWX_W_MATCH_LO): match_q[w][AWX_REG_W-1:0]          <= cfg_wdata;
                  WORD_W'(AWX_W_MATCH_HI): match_q[w][AWX_ADDR_W-1:AWX_REG_W] <= cfg_wdata;
                  WORD_W'(AWX_W_REMAP_LO): remap_q[w][AWX_REG_W-1:0]          <= cfg_wdata;
                  WORD_W'(AWX_W_REMAP_HI): remap_q[w][AWX_ADDR_W-1:AWX_REG_W] <= cfg_wdata;
                  WORD_W'(AWX_W_MASK_LO):  mask_q[w][AWX_REG_W-1:0]           <= cfg_wdata;
                  WORD_W'(AWX_W_MASK_HI):  mask_q[w][AWX_ADDR_W-1:AWX_REG_W]  <= cfg_wdata;
                  WORD_W'(AWX_W_ACTION): begin
                     kind_q[w] <= cfg_wdata[KIND_LSB +: AWX_KIND_W];
                     attr_q[w] <= cfg_wdata[ATTR_LSB +: AWX_ATTR_W];
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q <= 1'b0;
      end else if (cfg_we && at_ctrl) begin
         gen_q <= cfg_wdata[GEN_EN_BIT];
      end
   end

   // combinational read-back
   always_comb begin
      cfg_rdata = '0;
      if (at_ctrl) begin
         cfg_rdata[GEN_EN_BIT] = gen_q;
      end else if (in_win) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            if (widx == IDX_W'(w)) begin
               case (word)
                  WORD_W'(AWX_W_MATCH_LO): cfg_rdata = match_q[w][AWX_REG_W-1:0];
                  WORD_W'(AWX_W_MATCH_HI): cfg_rdata = match_q[w][AWX_ADDR_W-1:AWX_REG_W];
                  WORD_W'(AWX_W_REMAP_LO): cfg_rdata = remap_q[w][AWX_REG_W-1:0];
                  WORD_W'(AWX_W_REMAP_HI): cfg_rdata = remap_q[w][AWX_ADDR_W-1:AWX_REG_W];
                  WORD_W'(AWX_W_MASK_LO):  cfg_rdata = mask_q[w][AWX_REG_W-1:0];
                  WORD_W'(AWX_W_MASK_HI):  cfg_rdata = mask_q[w][AWX_ADDR_W-1:AWX_REG_W];
                  WORD_W'(AWX_W_ACTION): begin
                     cfg_rdata[KIND_LSB +: AWX_KIND_W] = kind_q[w];
                     cfg_rdata[ATTR_LSB +: AWX_ATTR_W] = attr_q[w];
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign win_match = match_q;
   assign win_mask  = mask_q;
   assign win_remap = remap_q;
   assign win_kind  = kind_q;
   assign win_attr  = attr_q;
   assign glob_en   = gen_q;

endmodule

// File: rtl/awx_win_cmp.sv
module awx_win_cmp
   import awx_pkg::*;
(
   input  logic [AWX_ADDR_W-1:0] addr,
   input  logic [AWX_ADDR_W-1:0] match,
   input  logic [AWX_ADDR_W-1:0] mask,
   input  logic [AWX_ADDR_W-1:0] remap,
   output logic                  hit,
   output logic [AWX_ADDR_W-1:0] xlat
);

   // bit 0 of the match word is the window enable, never an address bit
   localparam logic [AWX_ADDR_W-1:0] CMP_KEEP = ~AWX_ADDR_W'(1);

   logic                  live;
   logic [AWX_ADDR_W-1:0] diff;

   assign live = match[0];
   assign diff = (addr ^ match) & mask & CMP_KEEP;
   assign hit  = live && (diff == '0);
   assign xlat = (remap & mask) | (addr & ~mask);

endmodule

// File: rtl/awx_pick.sv
module awx_pick #(
   parameter int NUM_WIN    = 8,
   parameter bit ARITH_PICK = 1'b0
) (
   input  logic [NUM_WIN-1:0]         hits,
   output logic [NUM_WIN-1:0]         grant,
   output logic [$clog2(NUM_WIN)-1:0] idx,
   output logic                       any
);

   localparam int IDX_W = $clog2(NUM_WIN);

   if (NUM_WIN < 2) begin : g_bad_num
      $error("awx_pick needs at least two inputs");
   end

   if (ARITH_PICK) begin : g_arith
      // isolate lowest set bit with a two's complement trick
      assign grant = hits & (~hits + NUM_WIN'(1));
   end else begin : g_ripple
      always_comb begin
         logic found;
         found = 1'b0;
         grant = '0;
         for (int i = 0; i < NUM_WIN; i++) begin
            if (hits[i] && !found) begin
               grant[i] = 1'b1;
               found    = 1'b1;
            end
         end
      end
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (grant[i]) idx = idx | IDX_W'(i);
      end
   end

   assign any = |hits;

endmodule

// File: rtl/addr_win_xlate.sv
module addr_win_xlate
   import awx_pkg::*;
#(
   parameter int NUM_WIN    = 8,
   parameter int CFG_AW     = 12,
   parameter int WIN_STRIDE = 32,
   parameter int CTRL_OFS   = 256,
   parameter int GEN_EN_BIT = 6,
   parameter int KIND_LSB   = 0,
   parameter int ATTR_LSB   = 20,
   parameter bit ARITH_PICK = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [AWX_REG_W-1:0]  cfg_wdata,
   output logic [AWX_REG_W-1:0]  cfg_rdata,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [AWX_ADDR_W-1:0] in_addr,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [AWX_ADDR_W-1:0] out_addr,
   output logic                  out_hit,
   output logic [AWX_KIND_W-1:0] out_kind,
   output logic [AWX_ATTR_W-1:0] out_attr
);

   localparam int IDX_W = $clog2(NUM_WIN);

   logic [AWX_ADDR_W-1:0] win_match [NUM_WIN];
   logic [AWX_ADDR_W-1:0] win_mask  [NUM_WIN];
   logic [AWX_ADDR_W-1:0] win_remap [NUM_WIN];
   logic [AWX_KIND_W-1:0] win_kind  [NUM_WIN];
   logic [AWX_ATTR_W-1:0] win_attr  [NUM_WIN];
   logic                  glob_en;

   awx_regfile #(
      .NUM_WIN   (NUM_WIN),
      .CFG_AW    (CFG_AW),
      .WIN_STRIDE(WIN_STRIDE),
      .CTRL_OFS  (CTRL_OFS),
      .GEN_EN_BIT(GEN_EN_BIT),
      .KIND_LSB  (KIND_LSB),
      .ATTR_LSB  (ATTR_LSB)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .win_match(win_match),
      .win_mask (win_mask),
      .win_remap(win_remap),
      .win_kind (win_kind),
      .win_attr (win_attr),
      .glob_en  (glob_en)
   );

   logic [NUM_WIN-1:0]    hits;
   logic [AWX_ADDR_W-1:0] xlat [NUM_WIN];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      awx_win_cmp u_cmp (
         .addr (in_addr),
         .match(win_match[w]),
         .mask (win_mask[w]),
         .remap(win_remap[w]),
         .hit  (hits[w]),
         .xlat (xlat[w])
      );
   end

   logic [NUM_WIN-1:0] grant;
   logic [IDX_W-1:0]   sel_idx;
   logic               any_hit;

   awx_pick #(
      .NUM_WIN   (NUM_WIN),
      .ARITH_PICK(ARITH_PICK)
   ) u_pick (
      .hits (hits),
      .grant(grant),
      .idx  (sel_idx),
      .any  (any_hit)
   );

   logic      take;
   logic      accept;
   awx_resp_t resp_d;
   awx_resp_t resp_q;
   logic      vld_q;

   assign take     = glob_en && any_hit;
   assign in_ready = !vld_q || out_ready;
   assign accept   = in_valid && in_ready;

   always_comb begin
      if (take) begin
         resp_d.addr = xlat[sel_idx];
         resp_d.hit  = 1'b1;
         resp_d.kind = win_kind[sel_idx];
         resp_d.attr = win_attr[sel_idx];
      end else begin
         resp_d.addr = in_addr;
         resp_d.hit  = 1'b0;
         resp_d.kind = '0;
         resp_d.attr = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         resp_q <= '0;
      end else if (accept) begin
         vld_q  <= 1'b1;
         resp_q <= resp_d;
      end else if (out_ready) begin
         vld_q  <= 1'b0;
      end
   end

   assign out_valid = vld_q;
   assign out_addr  = resp_q.addr;
   assign out_hit   = resp_q.hit;
   assign out_kind  = resp_q.kind;
   assign out_attr  = resp_q.attr;

   // ---------------- assertions ----------------
   assert_accept_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);

   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_hit)
                                     && $stable(out_kind) && $stable(out_attr)));

   assert_miss_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !take) |=> (!out_hit && out_addr == $past(in_addr)
                             && out_kind == '0 && out_attr == '0));

   assert_gen_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !glob_en) |=> !out_hit);

   assert_grant_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~hits) == '0) && (any_hit == (grant != '0)));

   assert_grant_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> (((grant - NUM_WIN'(1)) & hits) == '0));

endmodule

// File: tb/addr_win_xlate_test.sv
module addr_win_xlate_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_addr = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] out_addr;
   logic        out_hit;
   logic [3:0]  out_kind;
   logic [1:0]  out_attr;

   always #5 clk = ~clk;

   addr_win_xlate uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .out_hit(out_hit), .out_kind(out_kind), .out_attr(out_attr)
   );

   typedef struct {
      logic [63:0] addr;
      logic        hit;
      logic [3:0]  kind;
      logic [1:0]  attr;
      int          cyc;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   fails  = 0;
   int   cyc    = 0;
   bit   bp_mode = 1'b0;

   // bench shadow of the programmed state, per R8/R9/R10
   logic [63:0] sh_match [8];
   logic [63:0] sh_mask  [8];
   logic [63:0] sh_remap [8];
   logic [3:0]  sh_kind  [8];
   logic [1:0]  sh_attr  [8];
   logic        sh_gen = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [63:0] a);
      exp_t e;
      e.addr = a; e.hit = 1'b0; e.kind = '0; e.attr = '0; e.cyc = 0; e.tag = "";
      if (sh_gen) begin
         for (int w = 7; w >= 0; w--) begin
            if (sh_match[w][0] && (((a ^ sh_match[w]) & sh_mask[w] & ~64'd1) == 64'd0)) begin
               e.addr = (sh_remap[w] & sh_mask[w]) | (a & ~sh_mask[w]);
               e.hit  = 1'b1;
               e.kind = sh_kind[w];
               e.attr = sh_attr[w];
            end
         end
      end
      return e;
   endfunction

   // all tasks start and end one time unit after a rising edge
   task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      if (a < 12'h100 && a[1:0] == 2'b00) begin
         case (a[4:2])
            3'd0: sh_match[a[7:5]][31:0]  = d;
            3'd1: sh_match[a[7:5]][63:32] = d;
            3'd2: sh_remap[a[7:5]][31:0]  = d;
            3'd3: sh_remap[a[7:5]][63:32] = d;
            3'd4: sh_mask[a[7:5]][31:0]   = d;
            3'd5: sh_mask[a[7:5]][63:32]  = d;
            3'd6: begin sh_kind[a[7:5]] = d[3:0]; sh_attr[a[7:5]] = d[21:20]; end
            default: ;
         endcase
      end else if (a == 12'h100) begin
         sh_gen = d[6];
      end
   endtask

   task automatic cfg_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
      cfg_addr = a;
      @(negedge clk);
      chk(cfg_rdata == exp, req, $sformatf("readback @%h", a), {40'd0, cfg_rdata}, {40'd0, exp});
      @(posedge clk); #1;
   endtask

   task automatic set_win(input int w, input logic [63:0] m, input logic [63:0] k,
                          input logic [63:0] r, input logic [31:0] act, input bit en);
      logic [11:0] b;
      b = 12'(w * 32);
      cfg_wr(b + 12'h00, {m[31:1], 1'b0});
      cfg_wr(b + 12'h04, m[63:32]);
      cfg_wr(b + 12'h08, r[31:0]);
      cfg_wr(b + 12'h0C, r[63:32]);
      cfg_wr(b + 12'h10, k[31:0]);
      cfg_wr(b + 12'h14, k[63:32]);
      cfg_wr(b + 12'h18, act);
      if (en) cfg_wr(b + 12'h00, {m[31:1], 1'b1});
   endtask

   task automatic send(input logic [63:0] a, input string tag);
      exp_t e;
      in_valid = 1'b1; in_addr = a;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      e = model(a);
      e.cyc = cyc;
      e.tag = tag;
      exp_q.push_back(e);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) begin
         @(posedge clk); #1;
      end
   endtask

   // out_ready pattern driver
   initial begin
      logic [4:0] lfsr;
      lfsr = 5'h13;
      forever begin
         @(posedge clk); #1;
         lfsr = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
         out_ready = bp_mode ? lfsr[0] : 1'b1;
      end
   end

   // monitor / scoreboard
   initial begin
      bit          held = 1'b0;
      logic [70:0] held_v = '0;
      logic [70:0] cur;
      exp_t        e;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            held = 1'b0;
         end else if (out_valid) begin
            cur = {out_addr, out_hit, out_kind, out_attr};
            if (held) begin
               chk(cur == held_v, "R7", "stalled result changed", {1'b0, cur}, {1'b0, held_v});
            end else if (exp_q.size() != 0) begin
               chk(cyc == exp_q[0].cyc + 1, "R7", "result latency",
                   72'(cyc), 72'(exp_q[0].cyc + 1));
            end
            if (out_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R7", "unexpected result", {1'b0, cur}, 72'd0);
               end else begin
                  e = exp_q.pop_front();
                  chk(cur == {e.addr, e.hit, e.kind, e.attr}, e.tag, "lookup result",
                      {1'b0, cur}, {1'b0, e.addr, e.hit, e.kind, e.attr});
               end
               held = 1'b0;
            end else begin
               held   = 1'b1;
               held_v = cur;
            end
         end else begin
            held = 1'b0;
         end
      end
   end

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired, queue=%0d expected=0", exp_q.size());
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int w = 0; w < 8; w++) begin
         sh_match[w] = '0; sh_mask[w] = '0; sh_remap[w] = '0; sh_kind[w] = '0; sh_attr[w] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", 72'(out_valid), 72'd0);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", 72'(in_ready), 72'd1);
      @(posedge clk); #1;
      cfg_chk(12'h000, 32'h0, "R1");
      cfg_chk(12'h0F4, 32'h0, "R1");
      cfg_chk(12'h100, 32'h0, "R1");

      // window 0: 128 MB memory window, high mask zero
      set_win(0, 64'h0000_0000_4000_0000, 64'h0000_0000_F800_0000,
              64'h0000_0000_E000_0000, 32'h0020_0000, 1'b1);
      cfg_chk(12'h000, 32'h4000_0001, "R8");
      cfg_chk(12'h010, 32'hF800_0000, "R8");
      cfg_chk(12'h018, 32'h0020_0000, "R9");

      // R10 global enable off: no hit, pass through
      send(64'h1234_5678_4123_4567, "R10");
      drain();
      cfg_wr(12'h100, 32'h0000_0040);
      cfg_chk(12'h100, 32'h0000_0040, "R10");

      // R3/R9 memory hit, upper bits pass through
      send(64'h1234_5678_4123_4567, "R3");
      send(64'h0000_0000_47FF_FFFC, "R9");
      send(64'h0000_0000_4800_0000, "R5");
      drain();

      // window 1: I/O window with full 64-bit mask
      set_win(1, 64'h0000_00AB_CDEF_0000, 64'hFFFF_FFFF_FFFF_0000,
              64'h0000_0001_0000_0000, 32'h0000_0004, 1'b1);
      send(64'h0000_00AB_CDEF_1234, "R3");
      send(64'h0000_00AC_CDEF_1234, "R5");
      drain();

      // R9 action keeps only its fields
      cfg_wr(12'h0F8, 32'hFFFF_FFFF);
      cfg_chk(12'h0F8, 32'h0030_000F, "R9");
      cfg_wr(12'h0F8, 32'h0);

      // R4 overlapping windows 2 and 5
      set_win(5, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FF00_0000,
              64'h0000_0005_0000_0000, 32'h0000_0004, 1'b1);
      set_win(2, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_F000_0000,
              64'h0000_0002_0000_0000, 32'h0020_0000, 1'b1);
      send(64'h0000_0000_8012_3456, "R4");
      send(64'h0000_0000_8912_3456, "R4");
      drain();
      // R6 turning window 2 off hands the overlap to window 5
      cfg_wr(12'h040, 32'h8000_0000);
      send(64'h0000_0000_8012_3456, "R6");
      send(64'h0000_0000_8912_3456, "R6");
      drain();

      // R6 window 3 programmed but never enabled
      set_win(3, 64'h0000_0000_C000_0000, 64'hFFFF_FFFF_F000_0000,
              64'h0000_0003_0000_0000, 32'h0000_0004, 1'b0);
      send(64'h0000_0000_C000_1000, "R6");
      drain();

      // R2 match bit 0 excluded from comparison
      set_win(4, 64'h0000_0000_1000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
              64'h2222_3333_4444_5555, 32'h0010_0000, 1'b1);
      send(64'h0000_0000_1000_0000, "R2");
      send(64'h0000_0000_1000_0001, "R2");
      send(64'h0000_0000_1000_0002, "R5");
      drain();

      // R8 unmapped offsets are ignored
      cfg_wr(12'h01C, 32'hDEAD_BEEF);
      cfg_wr(12'h1F0, 32'hDEAD_BEEF);
      cfg_wr(12'h002, 32'h0000_0000);
      cfg_chk(12'h01C, 32'h0, "R8");
      cfg_chk(12'h1F0, 32'h0, "R8");
      cfg_chk(12'h000, 32'h4000_0001, "R8");
      send(64'h1234_5678_4123_4567, "R8");
      drain();

      // R7 back-to-back stream under backpressure
      bp_mode = 1'b1;
      for (int i = 0; i < 16; i++) begin
         case (i % 4)
            0: send(64'h0000_0000_4000_0000 + 64'(i * 64), "R7");
            1: send(64'h0000_00AB_CDEF_0000 + 64'(i), "R7");
            2: send(64'h0000_0000_8000_0000 + 64'(i * 4096), "R7");
            default: send(64'h0000_0000_5000_0000 + 64'(i), "R7");
         endcase
      end
      drain();
      bp_mode = 1'b0;
      @(posedge clk); #1;

      // R10 global disable overrides every window
      cfg_wr(12'h100, 32'h0);
      send(64'h0000_00AB_CDEF_1234, "R10");
      send(64'h0000_0000_1000_0000, "R10");
      drain();

      repeat (3) @(posedge clk);
      chk(exp_q.size() == 0, "R7", "leftover results", 72'(exp_q.size()), 72'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule